// File: doc/BRIEF.md
# Four-Master Bus Arbiter with Parking

This block decides which of four masters may drive a shared memory bus. Each master raises its own request line and waits for its own grant line. The bus signals the last cycle of every bus cycle with a single `done` strobe, and the arbiter makes a new decision only on that strobe. A grant is never withdrawn while its owner is mid-cycle, and a request is never refused. A waiting request is served at a later decision.

A single 32-bit configuration register sets four things: a 2-bit rank for each master, a choice between a fixed-rank and a rotating decision rule, a park master, and a choice of parking on that master or on the last owner. A set of ranks with any duplicate is replaced by the reset ranks, and those reset ranks are what the register then reads back. When nobody owns the bus, the grant rests on the park target. That master can start at once, while any other master pays one dead clock of handover.

The controller has three states. `ST_PARK` means no owner, with the grant on the park target. `ST_SWITCH` is the one-clock dead handover, with no grant. `ST_OWN` means a master holds the bus until `done`.

The transitions are as follows:
- park-take (`ST_PARK`→`ST_OWN`): the park target requests.
- park-hand (`ST_PARK`→`ST_SWITCH`): another master wins.
- switch-land (`ST_SWITCH`→`ST_OWN`).
- own-keep (`ST_OWN`→`ST_OWN`): either there is no `done`, or the same owner wins again.
- own-hand (`ST_OWN`→`ST_SWITCH`): a different master wins on `done`.
- own-release (`ST_OWN`→`ST_PARK`): `done` arrives and nothing is requested.

Top module: `busarb_park`

## Requirements
- R1: Register layout and reset. Rank of master i sits in bits [2i+1:2i], and a smaller value means higher rank. Bit 8 selects the rule: 0 is fixed, 1 is rotating. Bits [10:9] hold the park master. Bit 11 selects the park target: 0 parks on the selected master, 1 parks on the last owner. After reset the register reads 0x000000E4 (ranks 0,1,2,3), and `gnt` is 4'b0001.
- R2: Bits [31:12] of the register always read 0, whatever was written.
- R3: A write whose four rank fields are not all different stores ranks 0,1,2,3 instead of the written ones. Bits [11:8] are still taken from the write.
- R4: Under the fixed rule, the requesting master with the smallest rank value wins.
- R5: Under the rotating rule, the winner is the first requester found searching upward (mod 4) from the master after the most recent owner. The last owner is master 0 after reset.
- R6: With no owner, `gnt` is one-hot on the park target.
- R7: A requesting park target keeps its grant with no dead cycle and takes the bus ahead of all other requesters.
- R8: Any other handover shows one cycle with `gnt` all zero. The new grant is visible two clock edges after the deciding edge's inputs.
- R9: An owner keeps its grant until `done`; a higher-ranked request does not preempt it.
- R10: At most one `gnt` bit is ever high.
- R11: A register write on the same edge as a `done` decision does not affect that decision. The new value governs the next one.
- R12: A request held high is eventually granted after the current owner completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-master bus request |
| done | input | 1 | Last cycle of the current owner's bus cycle |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | DW | Configuration write data |
| cfg_rdata | output | DW | Configuration register read value |
| gnt | output | 4 | Per-master grant, one-hot or zero |

## Verification
Two functions can fall on the same edge: a configuration write and the `done` decision. The bench provokes this by writing swapped ranks in exactly the cycle that ends the current owner's bus cycle, while two masters with opposite order under the old and new ranks are requesting. It judges the result by expecting the old order to pick the next owner and the new order to pick the one after it. The rest of the bench sweeps every legal rank permutation, every request pattern, both rules and every park target from an idle bus. It compares the grant timing against the winner and handover latency it computes itself.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    localparam int NM = 4;
    localparam int IW = $clog2(NM);
    localparam int PRIO_W    = NM * IW;
    localparam int MODE_BIT  = PRIO_W;
    localparam int PSEL_LSB  = PRIO_W + 1;
    localparam int PLAST_BIT = PSEL_LSB + IW;
    localparam int USED_W    = PLAST_BIT + 1;

    typedef logic [IW-1:0] mid_t;

    typedef struct packed {
        logic                    park_last;
        mid_t                    park_sel;
        logic                    rr;
        logic [NM-1:0][IW-1:0]   prio;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_PARK   = 2'd0,
        ST_SWITCH = 2'd1,
        ST_OWN    = 2'd2
    } st_t;

    function automatic logic [PRIO_W-1:0] prio_reset();
        logic [PRIO_W-1:0] v;
        for (int i = 0; i < NM; i++) v[i*IW +: IW] = mid_t'(i);
        return v;
    endfunction

    function automatic logic [NM-1:0] onehot(input mid_t i);
        logic [NM-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/busarb_cfg.sv
module busarb_cfg
    import busarb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic [DW-1:0] rdata
);
    localparam cfg_t CFG_RST = '{park_last: 1'b0, park_sel: '0, rr: 1'b0,
                                 prio: prio_reset()};

    logic [NM*NM-1:0] clash;
    cfg_t             cfg_q;

    // pairwise duplicate detection over the written rank fields
    for (genvar a = 0; a < NM; a++) begin : g_a
        for (genvar b = 0; b < NM; b++) begin : g_b
            if (b > a) begin : g_cmp
                assign clash[a*NM+b] = (wdata[a*IW +: IW] == wdata[b*IW +: IW]);
            end else begin : g_none
                assign clash[a*NM+b] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (we) begin
            cfg_q.prio      <= (|clash) ? prio_reset() : wdata[PRIO_W-1:0];
            cfg_q.rr        <= wdata[MODE_BIT];
            cfg_q.park_sel  <= wdata[PSEL_LSB +: IW];
            cfg_q.park_last <= wdata[PLAST_BIT];
        end
    end

    always_comb begin
        rdata                  = '0;
        rdata[PRIO_W-1:0]      = cfg_q.prio;
        rdata[MODE_BIT]        = cfg_q.rr;
        rdata[PSEL_LSB +: IW]  = cfg_q.park_sel;
        rdata[PLAST_BIT]       = cfg_q.park_last;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/busarb_pick.sv
module busarb_pick
    import busarb_pkg::*;
(
    input  logic [NM-1:0]         req,
    input  logic [NM-1:0][IW-1:0] prio,
    input  logic                  rr,
    input  mid_t                  rr_base,
    output logic                  win_v,
    output mid_t                  win_i
);
    logic fx_v, rr_v;
    mid_t fx_i, rr_i, best;

    // fixed rule: smallest rank value among requesters
    always_comb begin
        fx_v = 1'b0;
        fx_i = '0;
        best = '1;
        for (int i = 0; i < NM; i++) begin
            if (req[i] && (!fx_v || prio[i] < best)) begin
                fx_v = 1'b1;
                fx_i = mid_t'(i);
                best = prio[i];
            end
        end
    end

    // rotating rule: first requester above the base, wrapping
    always_comb begin
        mid_t idx;
        rr_v = 1'b0;
        rr_i = '0;
        for (int k = NM; k >= 1; k--) begin
            idx = rr_base + mid_t'(k);
            if (req[idx]) begin
                rr_v = 1'b1;
                rr_i = idx;
            end
        end
    end

    assign win_v = rr ? rr_v : fx_v;
    assign win_i = rr ? rr_i : fx_i;
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
    import busarb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req,
    input  logic          done,
    input  cfg_t          cfg,
    input  logic          win_v,
    input  mid_t          win_i,
    output mid_t          rr_base,
    output logic [NM-1:0] gnt
);
    st_t  st_q, st_d;
    mid_t owner_q, owner_d;
    mid_t last_q, last_d;
    mid_t tgt;
    logic tgt_busy, fin;
    mid_t fin_who;

    assign tgt      = cfg.park_last ? last_q : cfg.park_sel;
    assign tgt_busy = (st_q == ST_PARK) && req[tgt];
    assign fin      = done && ((st_q == ST_OWN) || tgt_busy);
    assign fin_who  = (st_q == ST_OWN) ? owner_q : tgt;
    assign rr_base  = (st_q == ST_OWN) ? owner_q : (tgt_busy ? tgt : last_q);

    // next state
    always_comb begin
        st_d    = st_q;
        owner_d = owner_q;
        last_d  = last_q;
        if (fin) begin
            last_d = fin_who;
            if (!win_v) begin
                st_d = ST_PARK;                 // own-release
            end else if (win_i == fin_who) begin
                st_d    = ST_OWN;               // own-keep
                owner_d = win_i;
            end else begin
                st_d    = ST_SWITCH;            // own-hand
                owner_d = win_i;
            end
        end else begin
            unique case (st_q)
                ST_PARK: begin
                    if (tgt_busy) begin
                        st_d    = ST_OWN;       // park-take
                        owner_d = tgt;
                    end else if (win_v) begin
                        st_d    = ST_SWITCH;    // park-hand
                        owner_d = win_i;
                    end
                end
                ST_SWITCH: st_d = ST_OWN;       // switch-land
                ST_OWN:    st_d = ST_OWN;       // own-keep
                default:   st_d = ST_PARK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_PARK;
            owner_q <= '0;
            last_q  <= '0;
        end else begin
            st_q    <= st_d;
            owner_q <= owner_d;
            last_q  <= last_d;
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_PARK:   gnt = onehot(tgt);
            ST_SWITCH: gnt = '0;
            ST_OWN:    gnt = onehot(owner_q);
            default:   gnt = '0;
        endcase
    end
endmodule

// File: rtl/busarb_park.sv
module busarb_park
    import busarb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    req,
    input  logic          done,
    input  logic          cfg_we,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    output logic [3:0]    gnt
);
    cfg_t cfg;
    logic win_v;
    mid_t win_i, rr_base;

    busarb_cfg #(.DW(DW)) i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    busarb_pick i_pick (
        .req     (req),
        .prio    (cfg.prio),
        .rr      (cfg.rr),
        .rr_base (rr_base),
        .win_v   (win_v),
        .win_i   (win_i)
    );

    busarb_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .done    (done),
        .cfg     (cfg),
        .win_v   (win_v),
        .win_i   (win_i),
        .rr_base (rr_base),
        .gnt     (gnt)
    );
endmodule

// File: rtl/busarb_park_chk.sv
module busarb_park_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    req,
    input logic          done,
    input logic [DW-1:0] cfg_rdata,
    input logic [3:0]    gnt
);
    p_gnt_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_hold_until_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(gnt & req)) && !done) |=> (gnt == $past(gnt)));

    p_gap_on_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(|(gnt & req)) && (gnt != $past(gnt))) |-> (gnt == 4'b0000));

    p_prio_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1:0] != cfg_rdata[3:2]) && (cfg_rdata[1:0] != cfg_rdata[5:4]) &&
        (cfg_rdata[1:0] != cfg_rdata[7:6]) && (cfg_rdata[3:2] != cfg_rdata[5:4]) &&
        (cfg_rdata[3:2] != cfg_rdata[7:6]) && (cfg_rdata[5:4] != cfg_rdata[7:6]));

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DW-1:12] == '0);
endmodule

bind busarb_park busarb_park_chk #(.DW(DW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .done      (done),
    .cfg_rdata (cfg_rdata),
    .gnt       (gnt)
);

// File: tb/test_busarb_park.sv
module test_busarb_park;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0;
    logic        done = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [3:0]  gnt;
    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int last = 0;

    always #5 clk = ~clk;

    busarb_park #(.DW(32)) i_busarb_park (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gnt(gnt)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit legal(input logic [7:0] p);
        return p[1:0] != p[3:2] && p[1:0] != p[5:4] && p[1:0] != p[7:6] &&
               p[3:2] != p[5:4] && p[3:2] != p[7:6] && p[5:4] != p[7:6];
    endfunction

    function automatic int fix_win(input logic [3:0] pat, input logic [7:0] p);
        int w = -1;
        int best = 99;
        for (int i = 0; i < 4; i++)
            if (pat[i] && int'(p[i*2 +: 2]) < best) begin best = int'(p[i*2 +: 2]); w = i; end
        return w;
    endfunction

    function automatic int rr_win(input logic [3:0] pat, input int base);
        for (int k = 1; k <= 4; k++) if (pat[(base + k) % 4]) return (base + k) % 4;
        return -1;
    endfunction

    function automatic logic [3:0] oh(input int i);
        return 4'b0001 << i;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; done = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        last = 0;
    endtask

    task automatic wr_cfg(input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one request from an idle bus; ends back in park state
    task automatic trial(input logic [3:0] pat, input int park, input int w);
        @(negedge clk);
        req = pat;
        #1 check("R6 park grant", {28'b0, gnt}, {28'b0, oh(park)});
        @(negedge clk);
        #1 if (pat[park]) check("R7 parked no gap", {28'b0, gnt}, {28'b0, oh(park)});
           else           check("R8 dead cycle", {28'b0, gnt}, 32'h0);
        @(negedge clk);
        #1 check("R4/R5 winner", {28'b0, gnt}, {28'b0, oh(w)});
        done = 1'b1; req = '0;
        @(negedge clk);
        done = 1'b0;
        last = w;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1 check("R1 reset rdata", cfg_rdata, 32'h0000_00E4);
        check("R1 reset gnt", {28'b0, gnt}, 32'h1);

        // R3 / R2: every rank combination, upper bits set
        for (int v = 0; v < 256; v++) begin
            logic [31:0] d, e;
            d = 32'hFFFF_F000 | (32'(v[3:0]) << 8) | 32'(v);
            e = (32'(v[3:0]) << 8) | (legal(8'(v)) ? 32'(v) : 32'hE4);
            wr_cfg(d);
            #1 check("R3/R2 readback", cfg_rdata, e);
        end

        // R4-R8 sweep
        do_reset();
        for (int rr = 0; rr < 2; rr++)
        for (int pl = 0; pl < 2; pl++)
        for (int ps = 0; ps < 4; ps++)
        for (int pv = 0; pv < 256; pv++) begin
            if (!legal(8'(pv)) || (rr == 1 && pv != 8'hE4)) continue;
            wr_cfg({20'b0, 1'(pl), 2'(ps), 1'(rr), 8'(pv)});
            for (int pat = 1; pat < 16; pat++) begin
                int park, w;
                park = pl ? last : ps;
                if (pat[park]) w = park;
                else w = rr ? rr_win(4'(pat), last) : fix_win(4'(pat), 8'(pv));
                trial(4'(pat), park, w);
            end
        end

        // R9 / R12 hold-off, then R11 same-edge write and decision
        do_reset();
        @(negedge clk); req = 4'b1000;
        @(negedge clk); #1 check("R8 gap before M3", {28'b0, gnt}, 32'h0);
        @(negedge clk); #1 check("R8 M3 granted", {28'b0, gnt}, 32'h8);
        req = 4'b1001;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1 check("R9 no preempt", {28'b0, gnt}, 32'h8);
        end
        done = 1'b1; req = 4'b0011; cfg_we = 1'b1; cfg_wdata = 32'h0000_00E1;
        @(negedge clk); done = 1'b0; cfg_we = 1'b0;
        #1 check("R11 new cfg visible", cfg_rdata, 32'h0000_00E1);
        check("R8 gap", {28'b0, gnt}, 32'h0);
        @(negedge clk); #1 check("R11 old ranks decide, R12 M0 served", {28'b0, gnt}, 32'h1);
        done = 1'b1;
        @(negedge clk); done = 1'b0; #1 check("R8 gap", {28'b0, gnt}, 32'h0);
        @(negedge clk); #1 check("R11 new ranks decide", {28'b0, gnt}, 32'h2);
        done = 1'b1; req = '0;
        @(negedge clk); done = 1'b0; #1 check("R6 back to park", {28'b0, gnt}, 32'h1);

        // R5 rotation with all four requesting
        do_reset();
        wr_cfg(32'h0000_01E4);
        @(negedge clk); req = 4'b1111;
        #1 check("R6 parked M0", {28'b0, gnt}, 32'h1);
        @(negedge clk); #1 check("R7 parked takes bus", {28'b0, gnt}, 32'h1);
        done = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk); done = 1'b0; #1 check("R8 rotation gap", {28'b0, gnt}, 32'h0);
            @(negedge clk); #1 check("R5 rotation", {28'b0, gnt}, {28'b0, oh(k % 4)});
            done = 1'b1;
        end
        req = '0;
        @(negedge clk); done = 1'b0; #1 check("R6 park after rotation", {28'b0, gnt}, 32'h1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule